// File: doc/BRIEF.md
# Stream CRC-16 Inserter with Loadable Polynomial Matrix

This block computes a 16-bit cyclic redundancy check over a packet stream of 32-bit words, one word per clock, and appends the result as an extra word behind the last data word of each packet. Packets are delimited by start and end strobes on the input side and may be of any length. The same strobes come out of the block, moved by the pipeline delay so that they stay aligned with the data.

The polynomial is not fixed in the logic. Every next-state CRC bit is the XOR of an AND between one stored coefficient row and the concatenation of the incoming word and the current CRC. The sixteen rows sit in a writable register bank, so a different polynomial is loaded at runtime through a row-addressed configuration port. The contribution of the data bits is computed one stage ahead of the CRC register, which keeps only the 16-wide state term inside the feedback loop.

A per-packet bypass control forwards a packet unchanged and appends no word. A per-packet error-inject control flips one bit of the appended CRC, so that the check at the far end can be tested.

The control is a three-state machine. ST_IDLE means no packet is open. ST_BODY means a packet is open and its words are passing through. ST_APPEND means the CRC word goes out on the next edge. The transitions are: IDLE to BODY on a start word without end. IDLE to APPEND on a one-word packet that is not bypassed. IDLE stays IDLE on a one-word bypassed packet. BODY to APPEND on an end word of a CRC packet. BODY to IDLE on an end word of a bypassed packet. APPEND always returns to IDLE.

Top module: `crc_frame_gen`

## Requirements
- R1: With the reset matrix, the appended CRC equals the MSB-first serial CRC-16 with polynomial 0x1021. Each word is fed from bit 31 down to bit 0. The register starts at 0xFFFF and no final XOR is applied.
- R2: The source leaves at least one idle input cycle after every end-of-packet word. A new packet may start on the cycle right after that single idle cycle and is still processed correctly.
- R3: Every input word appears unchanged on out_data two clock edges after it is presented, with out_valid set and out_sop set only on the first word of a packet.
- R4: For a CRC packet, the appended word follows the last data word on the next cycle. It holds the CRC in bits 15:0 and zero in bits 31:16. out_eop is set on the appended word and is clear on the last data word.
- R5: The CRC register restarts at 0xFFFF with every start-of-packet word. One-word packets and closely spaced packets therefore each get their own independent CRC.
- R6: A write to configuration row r sets next-CRC bit r. Coefficient bits 31:0 select input data bits 31:0 and bits 47:32 select current CRC bits 15:0. Loading the rows of polynomial 0x8005 makes the block produce that polynomial's CRC.
- R7: A configuration write is ignored while the block is busy: an input word is valid, a word is in the first stage, or a packet is open.
- R8: in_bypass, sampled with the start word, applies to the whole packet. Such a packet passes with the same latency, keeps out_eop on its last data word and gets no appended word.
- R9: in_inject, sampled with the end word, inverts bit 0 of that packet's appended CRC.
- R10: During and after reset, out_valid, out_sop, out_eop and out_data are zero, and the matrix holds the 0x1021 rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word valid |
| in_sop | input | 1 | First word of a packet |
| in_eop | input | 1 | Last word of a packet |
| in_data | input | 32 | Input data word |
| in_bypass | input | 1 | Forward packet without CRC (sampled with start word) |
| in_inject | input | 1 | Corrupt CRC bit 0 (sampled with end word) |
| cfg_we | input | 1 | Matrix row write strobe |
| cfg_row | input | 4 | Matrix row index (CRC output bit) |
| cfg_coef | input | 48 | Row coefficients: 31:0 data, 47:32 state |
| out_valid | output | 1 | Output word valid |
| out_sop | output | 1 | First output word of a packet |
| out_eop | output | 1 | Last output word of a packet |
| out_data | output | 32 | Output data or appended CRC word |

## Verification
The assertions check on every cycle the properties that depend only on the shape of the stream. When the machine is in ST_APPEND, the next output is a valid end word with zero upper half. Start and end strobes never appear without out_valid. The source honours the idle cycle after an end word, so the first stage is always empty when the CRC word goes out. A write attempted while busy leaves the matrix unchanged. The CRC values themselves can only be shown by the bench scenarios, which compare against a serial reference for both polynomials. The same holds for the two-edge latency, bypass and inject sampled per packet, restart at every start word, and the effect of a blocked write on later packets.

// File: rtl/crc_frame_pkg.sv
package crc_frame_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BODY   = 2'd1,
        ST_APPEND = 2'd2
    } pkt_state_e;

endpackage

// File: rtl/crc_coef_store.sv
module crc_coef_store #(
    parameter int DATA_W = 32,
    parameter int CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    localparam int ROW_W  = DATA_W + CRC_W,
    localparam int ROW_AW = $clog2(CRC_W)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ROW_AW-1:0]            wr_row,
    input  logic [ROW_W-1:0]             wr_coef,
    output logic [CRC_W-1:0][ROW_W-1:0]  rows_o
);

    // Serial, MSB-first update used only to derive the reset contents.
    function automatic logic [CRC_W-1:0] serial_step(input logic [CRC_W-1:0] s,
                                                     input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = s;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ d[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ POLY;
        end
        return c;
    endfunction

    function automatic logic [ROW_W-1:0] default_row(input int r);
        logic [ROW_W-1:0]  row;
        logic [CRC_W-1:0]  res;
        logic [DATA_W-1:0] d_unit;
        logic [CRC_W-1:0]  s_unit;
        row = '0;
        for (int c = 0; c < ROW_W; c++) begin
            d_unit = '0;
            s_unit = '0;
            if (c < DATA_W) d_unit[c] = 1'b1;
            else            s_unit[c-DATA_W] = 1'b1;
            res    = serial_step(s_unit, d_unit);
            row[c] = res[r];
        end
        return row;
    endfunction

    logic [CRC_W-1:0][ROW_W-1:0] rows_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < CRC_W; r++) rows_q[r] <= default_row(r);
        end else if (wr_en) begin
            for (int r = 0; r < CRC_W; r++) begin
                if (wr_row == ROW_AW'(r)) rows_q[r] <= wr_coef;
            end
        end
    end

    assign rows_o = rows_q;

endmodule

// File: rtl/crc_data_stage.sv
module crc_data_stage #(
    parameter int DATA_W = 32,
    parameter int CRC_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic                          in_sop,
    input  logic                          in_eop,
    input  logic [DATA_W-1:0]             in_data,
    input  logic                          in_bypass,
    input  logic                          in_inject,
    input  logic [CRC_W-1:0][DATA_W-1:0]  data_coef,
    output logic                          s1_valid,
    output logic                          s1_sop,
    output logic                          s1_eop,
    output logic [DATA_W-1:0]             s1_data,
    output logic                          s1_byp,
    output logic                          s1_inj,
    output logic [CRC_W-1:0]              s1_dpart
);

    logic [CRC_W-1:0] dpart_d;

    // Data contribution to every CRC bit, computed ahead of the feedback loop.
    for (genvar g = 0; g < CRC_W; g++) begin : g_dterm
        assign dpart_d[g] = ^(data_coef[g] & in_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_sop   <= 1'b0;
            s1_eop   <= 1'b0;
            s1_data  <= '0;
            s1_byp   <= 1'b0;
            s1_inj   <= 1'b0;
            s1_dpart <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_sop   <= in_valid & in_sop;
            s1_eop   <= in_valid & in_eop;
            s1_data  <= in_valid ? in_data : '0;
            s1_byp   <= in_bypass;
            s1_inj   <= in_inject;
            s1_dpart <= dpart_d;
        end
    end

endmodule

// File: rtl/crc_state_update.sv
module crc_state_update #(
    parameter int CRC_W = 16
) (
    input  logic [CRC_W-1:0]             base_state,
    input  logic [CRC_W-1:0]             dpart,
    input  logic [CRC_W-1:0][CRC_W-1:0]  state_coef,
    output logic [CRC_W-1:0]             next_state
);

    for (genvar g = 0; g < CRC_W; g++) begin : g_sterm
        assign next_state[g] = dpart[g] ^ (^(state_coef[g] & base_state));
    end

endmodule

// File: rtl/crc_frame_gen.sv
module crc_frame_gen
    import crc_frame_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CRC_W  = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    localparam int ROW_W  = DATA_W + CRC_W,
    localparam int ROW_AW = $clog2(CRC_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_sop,
    input  logic               in_eop,
    input  logic [DATA_W-1:0]  in_data,
    input  logic               in_bypass,
    input  logic               in_inject,
    input  logic               cfg_we,
    input  logic [ROW_AW-1:0]  cfg_row,
    input  logic [ROW_W-1:0]   cfg_coef,
    output logic               out_valid,
    output logic               out_sop,
    output logic               out_eop,
    output logic [DATA_W-1:0]  out_data
);

    pkt_state_e st_q, st_d;

    logic [CRC_W-1:0][ROW_W-1:0]  rows;
    logic [CRC_W-1:0][DATA_W-1:0] data_coef;
    logic [CRC_W-1:0][CRC_W-1:0]  state_coef;

    logic               s1_valid, s1_sop, s1_eop, s1_byp, s1_inj;
    logic [DATA_W-1:0]  s1_data;
    logic [CRC_W-1:0]   s1_dpart;

    logic [CRC_W-1:0]   crc_q, crc_base, crc_next;
    logic               byp_q, inj_q, cur_byp, busy, cfg_ok;

    for (genvar g = 0; g < CRC_W; g++) begin : g_split
        assign data_coef[g]  = rows[g][DATA_W-1:0];
        assign state_coef[g] = rows[g][ROW_W-1:DATA_W];
    end

    // R7: writes only land while nothing is in flight.
    assign busy   = in_valid | s1_valid | (st_q != ST_IDLE);
    assign cfg_ok = cfg_we & ~busy;

    crc_coef_store #(.DATA_W(DATA_W), .CRC_W(CRC_W), .POLY(POLY)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_ok),
        .wr_row  (cfg_row),
        .wr_coef (cfg_coef),
        .rows_o  (rows)
    );

    crc_data_stage #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_data   (in_data),
        .in_bypass (in_bypass),
        .in_inject (in_inject),
        .data_coef (data_coef),
        .s1_valid  (s1_valid),
        .s1_sop    (s1_sop),
        .s1_eop    (s1_eop),
        .s1_data   (s1_data),
        .s1_byp    (s1_byp),
        .s1_inj    (s1_inj),
        .s1_dpart  (s1_dpart)
    );

    // R5: restart from all ones on the start word.
    assign crc_base = s1_sop ? {CRC_W{1'b1}} : crc_q;
    // R8: bypass of the current word comes from the start word of its packet.
    assign cur_byp  = s1_sop ? s1_byp : byp_q;

    crc_state_update #(.CRC_W(CRC_W)) u_upd (
        .base_state (crc_base),
        .dpart      (s1_dpart),
        .state_coef (state_coef),
        .next_state (crc_next)
    );

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (s1_valid && s1_sop) begin
                    if (!s1_eop)     st_d = ST_BODY;
                    else if (s1_byp) st_d = ST_IDLE;
                    else             st_d = ST_APPEND;
                end
            end
            ST_BODY: begin
                if (s1_valid && s1_eop) st_d = byp_q ? ST_IDLE : ST_APPEND;
            end
            ST_APPEND: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register and per-packet context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            crc_q <= '0;
            byp_q <= 1'b0;
            inj_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (s1_valid && s1_sop)            byp_q <= s1_byp;
            if (s1_valid && s1_eop)            inj_q <= s1_inj;
            if (s1_valid && !cur_byp)          crc_q <= crc_next;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
            out_data  <= '0;
        end else if (st_q == ST_APPEND) begin
            out_valid <= 1'b1;
            out_sop   <= 1'b0;
            out_eop   <= 1'b1;
            out_data  <= {{(DATA_W-CRC_W){1'b0}},
                          crc_q ^ {{(CRC_W-1){1'b0}}, inj_q}};
        end else begin
            out_valid <= s1_valid;
            out_sop   <= s1_sop;
            out_eop   <= s1_eop & cur_byp;
            out_data  <= s1_data;
        end
    end

endmodule

// File: rtl/crc_frame_chk.sv
module crc_frame_chk
    import crc_frame_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CRC_W  = 16,
    localparam int ROW_W = DATA_W + CRC_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_eop,
    input  logic                     out_valid,
    input  logic                     out_sop,
    input  logic                     out_eop,
    input  logic [DATA_W-1:0]        out_data,
    input  pkt_state_e               st_q,
    input  logic                     s1_valid,
    input  logic                     cfg_we,
    input  logic                     busy,
    input  logic [CRC_W*ROW_W-1:0]   rows
);

    assert_append_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_APPEND) |=> (out_valid && out_eop && !out_sop &&
                                 out_data[DATA_W-1:CRC_W] == '0));

    assert_flags_need_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop || out_eop) |-> out_valid);

    assert_src_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_eop) |=> !in_valid);

    assert_no_slot_clash_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_APPEND) |-> !s1_valid);

    assert_busy_write_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && busy) |=> $stable(rows));

endmodule

bind crc_frame_gen crc_frame_chk #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data),
    .st_q      (st_q),
    .s1_valid  (s1_valid),
    .cfg_we    (cfg_we),
    .busy      (busy),
    .rows      (rows)
);

// File: tb/crc_frame_gen_bench.sv
`timescale 1ns/1ps
module crc_frame_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_bypass = 1'b0, in_inject = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_row = '0;
    logic [47:0] cfg_coef = '0;
    logic        out_valid, out_sop, out_eop;
    logic [31:0] out_data;

    always #4 clk = ~clk;   // 125 MHz

    crc_frame_gen u_crc_frame_gen (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_bypass(in_bypass), .in_inject(in_inject),
        .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_coef(cfg_coef),
        .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
    );

    typedef struct packed {
        logic        sop;
        logic        eop;
        logic [31:0] data;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    string       cur_tag = "R10";
    logic [15:0] cur_poly = 16'h1021;
    logic [31:0] pkt_buf [0:63];
    int          cyc = 0;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_step(input logic [15:0] poly,
                                             input logic [15:0] s, input logic [31:0] d);
        logic [15:0] c = s;
        for (int i = 31; i >= 0; i--) begin
            if (c[15] ^ d[i]) c = (c << 1) ^ poly;
            else              c = c << 1;
        end
        return c;
    endfunction

    function automatic logic [15:0] ref_crc(input logic [15:0] poly, input int n);
        logic [15:0] c = 16'hFFFF;
        for (int w = 0; w < n; w++) c = ref_step(poly, c, pkt_buf[w]);
        return c;
    endfunction

    function automatic logic [47:0] ref_row(input logic [15:0] poly, input int r);
        logic [47:0] row = '0;
        logic [15:0] res;
        for (int c = 0; c < 48; c++) begin
            if (c < 32) res = ref_step(poly, 16'h0, 32'h1 << c);
            else        res = ref_step(poly, 16'h1 << (c - 32), 32'h0);
            row[c] = res[r];
        end
        return row;
    endfunction

    // Output monitor: every valid output word is compared to the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected word", {30'h0, out_sop, out_eop, out_data}, 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check({out_sop, out_eop, out_data} == e, cur_tag, "sop/eop/data",
                      {30'h0, out_sop, out_eop, out_data}, {30'h0, e});
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic drive(input bit v, input bit s, input bit e, input logic [31:0] d,
                         input bit b, input bit j);
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_data = d;
        in_bypass = b; in_inject = j;
        cfg_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 32'h0, $urandom % 2, $urandom % 2);
    endtask

    // cfg_at >= 0 attempts a matrix write (row 0 to zeros) during that word.
    task automatic send_packet(input int len, input bit byp, input bit inj, input int cfg_at);
        logic [15:0] crc;
        for (int k = 0; k < len; k++) pkt_buf[k] = $urandom;
        crc = ref_crc(cur_poly, len);
        for (int k = 0; k < len; k++)
            exp_q.push_back({k == 0, (k == len - 1) && byp, pkt_buf[k]});
        if (!byp) exp_q.push_back({1'b0, 1'b1, 16'h0, crc ^ {15'h0, inj}});
        for (int k = 0; k < len; k++) begin
            // bypass only matters on the first word, inject only on the last
            drive(1, k == 0, k == len - 1, pkt_buf[k],
                  (k == 0) ? byp : ($urandom % 2),
                  (k == len - 1) ? inj : ($urandom % 2));
            if (k == cfg_at) begin
                cfg_we = 1'b1; cfg_row = 4'd0; cfg_coef = 48'h0;
            end
        end
        drive(0, 0, 0, 32'h0, 0, 0);   // mandatory gap (R2)
    endtask

    task automatic load_poly(input logic [15:0] poly);
        idle(4);
        for (int r = 0; r < 16; r++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_row = 4'(r); cfg_coef = ref_row(poly, r);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        cur_poly = poly;
        idle(2);
    endtask

    task automatic drain(input string tag);
        idle(6);
        check(exp_q.size() == 0, tag, "words left", 64'(exp_q.size()), 64'h0);
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R10: reset state
        check({out_valid, out_sop, out_eop} == 3'b000, "R10", "flags in reset",
              {61'h0, out_valid, out_sop, out_eop}, 64'h0);
        check(out_data == 32'h0, "R10", "data in reset", 64'(out_data), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        check({out_valid, out_sop, out_eop} == 3'b000, "R10", "flags after reset",
              {61'h0, out_valid, out_sop, out_eop}, 64'h0);

        // R3: exact two-edge latency on a bypassed one-word packet
        cur_tag = "R3";
        exp_q.push_back({1'b1, 1'b1, 32'hA5C3_1E77});
        drive(1, 1, 1, 32'hA5C3_1E77, 1, 0);
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
        check(out_valid == 1'b0, "R3", "not yet valid after one edge", 64'(out_valid), 64'h0);
        @(negedge clk);
        check(out_valid && out_data == 32'hA5C3_1E77, "R3", "word after two edges",
              64'(out_data), 64'hA5C3_1E77);
        drain("R3");

        // R1 / R4: default polynomial, directed lengths
        cur_tag = "R1 R4";
        send_packet(4, 0, 0, -1);
        send_packet(9, 0, 0, -1);
        drain("R1");

        // R5: one-word packets and R2: exactly one idle cycle between packets
        cur_tag = "R5 R2";
        send_packet(1, 0, 0, -1);
        send_packet(1, 0, 0, -1);
        send_packet(3, 0, 0, -1);
        send_packet(2, 0, 0, -1);
        drain("R5");

        // R8: bypassed packets, including one between CRC packets
        cur_tag = "R8";
        send_packet(5, 1, 0, -1);
        send_packet(2, 0, 0, -1);
        send_packet(1, 1, 1, -1);
        drain("R8");

        // R9: inject flips CRC bit 0
        cur_tag = "R9";
        send_packet(6, 0, 1, -1);
        send_packet(1, 0, 1, -1);
        drain("R9");

        // R7: write attempted mid-packet is dropped; next packet still uses old rows
        cur_tag = "R7";
        send_packet(4, 0, 0, 1);
        send_packet(3, 0, 0, -1);
        drain("R7");

        // Random mix with the default polynomial
        cur_tag = "R1 R4 R8 R9";
        for (int p = 0; p < 40; p++) begin
            send_packet(1 + ($urandom % 10), ($urandom % 5) == 0, ($urandom % 5) == 0, -1);
            if ($urandom % 2) idle($urandom % 3);
        end
        drain("R1");

        // R6: load 0x8005 rows, then random packets
        load_poly(16'h8005);
        cur_tag = "R6";
        for (int p = 0; p < 25; p++) begin
            send_packet(1 + ($urandom % 12), ($urandom % 6) == 0, ($urandom % 4) == 0, -1);
            if ($urandom % 2) idle(1);
        end
        drain("R6");

        // R6: restore 0x1021 by writing its rows
        load_poly(16'h1021);
        cur_tag = "R6";
        send_packet(7, 0, 0, -1);
        drain("R6");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule